// File: doc/BRIEF.md
# Serial Peripheral Bus Port Bridge

This block joins one 8-bit parallel port, built from a data latch and a data-direction register, to a three-wire serial peripheral bus. The three wires are attention, clock and data, and a service-request line runs alongside them. Three latch bits drive the outgoing bus wires through inverters. The incoming clock and data levels come back, also inverted, into two other bits of the same latch. A CPU reads the port to see both what it drives and what the bus shows.

Two active-low sources share one flag input of a timer/port chip: the bus service-request line and the cassette read line. The block merges them into that input. It also holds the reset line offered to external bus devices permanently inactive.

Every incoming level passes through a two-stage synchroniser before it is used. The bus wire outputs are registered, so they follow the latch one clock later.

Top module: `sbp_top`

## Requirements
- R1: While reset is asserted, and directly after it, the latch reads 0xFF, the direction register reads 0xFF, all three bus wire outputs are 0 and the flag output is 1.
- R2: A CPU data write changes the latch only in bit positions whose direction bit is 1 (output). The new value is visible on the read port one clock after the write cycle.
- R3: Attention out is 1 exactly when latch bit 3 is 0. Clock out is 1 exactly when bit 4 is 0. Data out is 1 exactly when bit 5 is 0. Each output lags the latch by one clock.
- R4: When direction bit 6 is 0, latch bit 6 takes the inverse of the incoming clock level. When direction bit 7 is 0, latch bit 7 takes the inverse of the incoming data level. The new value shows on the read port three clocks after the level changes.
- R5: Incoming bus levels never change a latch bit whose direction bit is 1.
- R6: The flag output is the AND of the service-request line and the cassette read line, both active low. It follows them two clocks after a change.
- R7: The reset line to external devices is always 1.
- R8: A direction write loads the direction register in one clock. If a data write lands in the same cycle, it is masked by the direction value from before that cycle.
- R9: Latch bits 0 to 5 that are configured as inputs keep their last value, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| cpu_wr_data_i | input | 1 | Write strobe for the port data latch |
| cpu_wr_dir_i | input | 1 | Write strobe for the direction register |
| cpu_wdata_i | input | 8 | Write data |
| port_rdata_o | output | 8 | Current latch value (read port) |
| port_dir_o | output | 8 | Current direction register (1 = output) |
| bus_clk_lvl_i | input | 1 | Incoming bus clock level; 1 clears bit 6 |
| bus_data_lvl_i | input | 1 | Incoming bus data level; 1 clears bit 7 |
| bus_srq_n_i | input | 1 | Service-request line, active low |
| cass_rd_n_i | input | 1 | Cassette read line, active low |
| bus_atn_o | output | 1 | Attention wire drive, 1 = asserted |
| bus_clk_o | output | 1 | Clock wire drive, 1 = asserted |
| bus_data_o | output | 1 | Data wire drive, 1 = asserted |
| flag_n_o | output | 1 | Merged active-low flag to the timer/port chip |
| dev_reset_n_o | output | 1 | Reset to external devices, held high |

## Verification
Data writes with the direction register at 0xFF, at 0x3F and at 0x0F show whether masking uses the correct register, and whether input bits 0 to 5 keep their value. The bench changes the incoming clock and data levels in opposite directions, one at a time. This catches a swapped bit position or a missing inversion. Those levels are also changed while bits 6 and 7 are outputs, to show that the direction register gates the fold-back. The flag is driven through all four low/high pairings of its two sources, which separates an AND from an OR or from a single source.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
    localparam int PORT_W       = 8;
    localparam int SYNC_STAGES  = 2;
    localparam int ATN_BIT      = 3;
    localparam int CLK_OUT_BIT  = 4;
    localparam int DATA_OUT_BIT = 5;
    localparam int CLK_IN_BIT   = 6;
    localparam int DATA_IN_BIT  = 7;

    typedef struct packed {
        logic atn;
        logic clk;
        logic data;
    } bus_drive_t;
endpackage

// File: rtl/sbp_sync.sv
module sbp_sync #(
    parameter int           N       = 2,
    parameter int           STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] stage_d [STAGES];
    logic [N-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        for (int s = 0; s < STAGES; s++) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_d[s];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sbp_port_latch.sv
module sbp_port_latch #(
    parameter int W        = 8,
    parameter int CLK_BIT  = 6,
    parameter int DATA_BIT = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_data_en_i,
    input  logic         wr_dir_en_i,
    input  logic [W-1:0] wdata_i,
    input  logic         ext_clk_lvl_i,
    input  logic         ext_data_lvl_i,
    output logic [W-1:0] lat_o,
    output logic [W-1:0] dir_o
);
    localparam logic [W-1:0] FOLD_MASK = (W'(1) << CLK_BIT) | (W'(1) << DATA_BIT);

    typedef struct packed {
        logic [W-1:0] lat;
        logic [W-1:0] dir;
    } latch_st_t;

    latch_st_t st_d, st_q;
    logic [W-1:0] ext_img;
    logic [W-1:0] fold_en;

    always_comb begin
        st_d = st_q;
        if (wr_data_en_i) begin
            st_d.lat = (st_q.lat & ~st_q.dir) | (wdata_i & st_q.dir);
        end
        ext_img           = st_d.lat;
        ext_img[CLK_BIT]  = ~ext_clk_lvl_i;
        ext_img[DATA_BIT] = ~ext_data_lvl_i;
        fold_en           = FOLD_MASK & ~st_q.dir;
        st_d.lat          = (st_d.lat & ~fold_en) | (ext_img & fold_en);
        if (wr_dir_en_i) begin
            st_d.dir = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lat: '1, dir: '1};
        else        st_q <= st_d;
    end

    assign lat_o = st_q.lat;
    assign dir_o = st_q.dir;

    logic past_valid_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_valid_q <= 1'b0;
        else        past_valid_q <= 1'b1;
    end

    // R2
    out_bits_follow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_en_i |=> ((lat_o & $past(dir_o)) == ($past(wdata_i) & $past(dir_o))));

    // R5
    out_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid_q && !$past(wr_data_en_i)) |-> (((lat_o ^ $past(lat_o)) & $past(dir_o)) == '0));

    // R4
    clk_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid_q && !$past(dir_o[CLK_BIT])) |-> (lat_o[CLK_BIT] == !$past(ext_clk_lvl_i)));

    // R4
    data_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid_q && !$past(dir_o[DATA_BIT])) |-> (lat_o[DATA_BIT] == !$past(ext_data_lvl_i)));

    // R9
    low_in_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid_q |-> (((lat_o ^ $past(lat_o)) & ~$past(dir_o) & ~FOLD_MASK) == '0));

    // R8
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir_en_i |=> (dir_o == $past(wdata_i)));
endmodule

// File: rtl/sbp_bus_drive.sv
module sbp_bus_drive
    import sbp_pkg::*;
#(
    parameter int W        = 8,
    parameter int A_BIT    = 3,
    parameter int C_BIT    = 4,
    parameter int D_BIT    = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lat_i,
    input  logic         srq_s_i,
    input  logic         cass_s_i,
    output bus_drive_t   drive_o,
    output logic         flag_n_o
);
    bus_drive_t drv_d, drv_q;

    always_comb begin
        drv_d.atn  = ~lat_i[A_BIT];
        drv_d.clk  = ~lat_i[C_BIT];
        drv_d.data = ~lat_i[D_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drv_q <= '0;
        else        drv_q <= drv_d;
    end

    assign drive_o  = drv_q;
    assign flag_n_o = srq_s_i & cass_s_i;

    logic past_valid_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_valid_q <= 1'b0;
        else        past_valid_q <= 1'b1;
    end

    // R3
    wire_drive_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid_q |-> (drive_o == {!$past(lat_i[A_BIT]), !$past(lat_i[C_BIT]), !$past(lat_i[D_BIT])}));
endmodule

// File: rtl/sbp_top.sv
module sbp_top
    import sbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_data_i,
    input  logic              cpu_wr_dir_i,
    input  logic [PORT_W-1:0] cpu_wdata_i,
    output logic [PORT_W-1:0] port_rdata_o,
    output logic [PORT_W-1:0] port_dir_o,
    input  logic              bus_clk_lvl_i,
    input  logic              bus_data_lvl_i,
    input  logic              bus_srq_n_i,
    input  logic              cass_rd_n_i,
    output logic              bus_atn_o,
    output logic              bus_clk_o,
    output logic              bus_data_o,
    output logic              flag_n_o,
    output logic              dev_reset_n_o
);
    localparam int CNT_W = $clog2(SYNC_STAGES + 1);

    logic [1:0]  lvl_s;
    logic [1:0]  flg_s;
    logic [PORT_W-1:0] lat;
    bus_drive_t  drive;

    sbp_sync #(.N(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_lvl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({bus_clk_lvl_i, bus_data_lvl_i}),
        .q_o   (lvl_s)
    );

    sbp_sync #(.N(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_flag_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({bus_srq_n_i, cass_rd_n_i}),
        .q_o   (flg_s)
    );

    sbp_port_latch #(.W(PORT_W), .CLK_BIT(CLK_IN_BIT), .DATA_BIT(DATA_IN_BIT)) u_latch (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_data_en_i   (cpu_wr_data_i),
        .wr_dir_en_i    (cpu_wr_dir_i),
        .wdata_i        (cpu_wdata_i),
        .ext_clk_lvl_i  (lvl_s[1]),
        .ext_data_lvl_i (lvl_s[0]),
        .lat_o          (lat),
        .dir_o          (port_dir_o)
    );

    sbp_bus_drive #(.W(PORT_W), .A_BIT(ATN_BIT), .C_BIT(CLK_OUT_BIT), .D_BIT(DATA_OUT_BIT)) u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .lat_i    (lat),
        .srq_s_i  (flg_s[1]),
        .cass_s_i (flg_s[0]),
        .drive_o  (drive),
        .flag_n_o (flag_n_o)
    );

    assign port_rdata_o  = lat;
    assign bus_atn_o     = drive.atn;
    assign bus_clk_o     = drive.clk;
    assign bus_data_o    = drive.data;
    assign dev_reset_n_o = 1'b1;

    // Run-length counters of stable flag sources, used only by the checks below.
    logic [CNT_W-1:0] srq_lo_q, cass_lo_q, both_hi_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srq_lo_q  <= '0;
            cass_lo_q <= '0;
            both_hi_q <= '0;
        end else begin
            srq_lo_q  <= bus_srq_n_i ? '0 : (srq_lo_q  == CNT_W'(SYNC_STAGES) ? srq_lo_q  : srq_lo_q  + 1'b1);
            cass_lo_q <= cass_rd_n_i ? '0 : (cass_lo_q == CNT_W'(SYNC_STAGES) ? cass_lo_q : cass_lo_q + 1'b1);
            both_hi_q <= !(bus_srq_n_i && cass_rd_n_i) ? '0 :
                         (both_hi_q == CNT_W'(SYNC_STAGES) ? both_hi_q : both_hi_q + 1'b1);
        end
    end

    // R6
    flag_srq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srq_lo_q == CNT_W'(SYNC_STAGES)) |-> !flag_n_o);

    // R6
    flag_cass_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cass_lo_q == CNT_W'(SYNC_STAGES)) |-> !flag_n_o);

    // R6
    flag_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (both_hi_q == CNT_W'(SYNC_STAGES)) |-> flag_n_o);
endmodule

// File: tb/sbp_top_bench.sv
`timescale 1ns/1ps
module sbp_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_data = 1'b0, wr_dir = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       clk_lvl = 1'b0, data_lvl = 1'b0, srq_n = 1'b1, cass_n = 1'b1;
    logic [7:0] rdata, dir;
    logic       atn_o, clko, datao, flag_n, devrst_n;

    always #2 clk = ~clk;

    sbp_top u_sbp_top (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_data_i(wr_data), .cpu_wr_dir_i(wr_dir), .cpu_wdata_i(wdata),
        .port_rdata_o(rdata), .port_dir_o(dir),
        .bus_clk_lvl_i(clk_lvl), .bus_data_lvl_i(data_lvl),
        .bus_srq_n_i(srq_n), .cass_rd_n_i(cass_n),
        .bus_atn_o(atn_o), .bus_clk_o(clko), .bus_data_o(datao),
        .flag_n_o(flag_n), .dev_reset_n_o(devrst_n)
    );

    // kinds: 0 read port, 1 {atn,clk,data}, 2 flag, 3 direction, 4 device reset
    typedef struct {
        int         cyc;
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    int    cyc = 0;
    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;

    logic [7:0] m_lat = 8'hFF, m_dir = 8'hFF;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] actual(int kind);
        case (kind)
            0: return rdata;
            1: return {5'b0, atn_o, clko, datao};
            2: return {7'b0, flag_n};
            3: return dir;
            default: return {7'b0, devrst_n};
        endcase
    endfunction

    // monitor: pops and compares items due at this cycle
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
            item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            act = actual(it.kind);
            n_cmp++;
            if (it.cyc != cyc || act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d cyc=%0d actual=%h expected=%h", it.tag, it.kind, cyc, act, it.exp);
            end
        end
    end

    task automatic push(int c, int k, logic [7:0] e, string t);
        item_t it;
        it.cyc = c; it.kind = k; it.exp = e; it.tag = t;
        sb_q.push_back(it);
    endtask

    function automatic logic [7:0] drv_of(logic [7:0] l);
        return {5'b0, ~l[3], ~l[4], ~l[5]};
    endfunction

    function automatic logic [7:0] fold(logic [7:0] l, logic [7:0] d);
        logic [7:0] r = l;
        if (!d[6]) r[6] = ~clk_lvl;
        if (!d[7]) r[7] = ~data_lvl;
        return r;
    endfunction

    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic cpu_write(bit do_data, bit do_dir, logic [7:0] v, string t);
        int n;
        logic [7:0] old_lat;
        @(negedge clk);
        n = cyc;
        wr_data = do_data; wr_dir = do_dir; wdata = v;
        old_lat = m_lat;
        m_lat = fold(m_lat, m_dir);
        if (do_data) m_lat = (m_lat & ~m_dir) | (v & m_dir);
        if (do_dir) m_dir = v;
        if (do_data) push(n + 1, 0, m_lat, t);
        push(n + 1, 1, drv_of(old_lat), "R3");
        push(n + 1, 3, m_dir, do_dir ? "R8" : t);
        push(n + 2, 1, drv_of(m_lat), "R3");
        m_lat = fold(m_lat, m_dir);
        push(n + 3, 0, m_lat, t);
        @(negedge clk);
        wr_data = 0; wr_dir = 0;
        idle(4);
    endtask

    task automatic bus_levels(logic c, logic d, string t);
        int n;
        @(negedge clk);
        n = cyc;
        push(n + 2, 0, m_lat, t);
        clk_lvl = c; data_lvl = d;
        m_lat = fold(m_lat, m_dir);
        push(n + 3, 0, m_lat, t);
        idle(5);
    endtask

    task automatic flag_src(logic s, logic c);
        int n;
        logic old;
        @(negedge clk);
        n = cyc;
        old = srq_n & cass_n;
        srq_n = s; cass_n = c;
        push(n + 1, 2, {7'b0, old}, "R6");
        push(n + 2, 2, {7'b0, s & c}, "R6");
        idle(4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1: during reset
        push(cyc + 1, 0, 8'hFF, "R1");
        push(cyc + 1, 3, 8'hFF, "R1");
        push(cyc + 1, 1, 8'h00, "R1");
        push(cyc + 1, 2, 8'h01, "R1");
        push(cyc + 1, 4, 8'h01, "R7");
        idle(1);
        rst_n = 1'b1;
        push(cyc + 2, 0, 8'hFF, "R1");
        push(cyc + 2, 1, 8'h00, "R1");
        push(cyc + 2, 2, 8'h01, "R1");
        idle(3);

        cpu_write(1, 0, 8'h00, "R2");          // all outputs asserted
        cpu_write(1, 0, 8'h08, "R2");          // attention released
        bus_levels(1, 1, "R5");                 // bits 6/7 are outputs: no change
        cpu_write(0, 1, 8'h3F, "R8");          // bits 6/7 become inputs
        bus_levels(0, 1, "R4");                 // clk low -> bit6 set
        bus_levels(1, 0, "R4");                 // data low -> bit7 set
        cpu_write(1, 0, 8'hFF, "R2");          // inputs keep folded bits
        cpu_write(0, 1, 8'h0F, "R8");
        cpu_write(1, 0, 8'h00, "R9");          // bits 4,5 are inputs: hold 1
        bus_levels(0, 0, "R4");
        cpu_write(1, 1, 8'hAA, "R8");          // same-cycle: old dir masks
        bus_levels(1, 1, "R5");
        cpu_write(1, 0, 8'h55, "R2");

        flag_src(1'b0, 1'b1);
        flag_src(1'b1, 1'b0);
        flag_src(1'b1, 1'b1);
        flag_src(1'b0, 1'b0);
        flag_src(1'b1, 1'b1);

        push(cyc + 1, 4, 8'h01, "R7");
        idle(4);

        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard left %0d items", sb_q.size());
        end
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule